// File: doc/BRIEF.md
# DRAM Strobe Decoder with Refresh Counter

This block is a synthesizable device-side model of an asynchronous-strobe DRAM's control logic. It samples the active-low row strobe, the two per-byte column strobes, the write strobe and the output-enable strobe once per clock. From the order in which the strobes fall it decides which kind of cycle is running. The kinds are standby, refresh from an internal row counter, refresh from a row given on the address pins, and byte or word reads and writes. It captures row and column addresses and drives per-lane output enables for the data bus. It holds the data in a small two-lane register file.

Refresh is told apart from an access by whether a column strobe is already low when the row strobe falls. An early write is told apart from a write controlled by the output enable by whether the write strobe is already low when the first column strobe falls. All outputs are registered and reflect the pins sampled at the previous rising clock edge.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: While the row strobe is high the block is in standby: `cyc_type` reads 0 and both bits of `dq_oe` are 0.
- R2: If either column strobe is low when the row strobe falls, the cycle is a counter refresh. `cyc_type` reads 1 and `rf_pulse` is 1 for one clock. `rf_row` shows the internal counter value, and the counter then advances by one. The counter reads 0 after reset.
- R3: If both column strobes are high when the row strobe falls, `rf_pulse` is 1 and `rf_row` equals `addr`. While the row strobe is low with both column strobes high, `cyc_type` reads 2. The internal counter does not move.
- R4: In an access, with the write strobe high and the output enable low, each lane whose column strobe is low drives stored data. Lane 0 uses the lower strobe and `dq_out[7:0]`, and lane 1 uses the upper strobe and `dq_out[15:8]`. The matching bit of `dq_oe` is set and the other bit stays 0. `cyc_type` reads 3.
- R5: In an access with the write strobe low, only lanes whose column strobe is low store their byte of `dq_in`. `dq_oe` is 0 and `cyc_type` reads 4.
- R6: If the write strobe is low when the first column strobe falls, the column cycle is an early write. `dq_oe` stays 0 until both column strobes are high, even if the write strobe rises and the output enable goes low. In that state `cyc_type` reads 5.
- R7: A column cycle that starts as a read may switch to a write when the write strobe later falls. The data is stored, and `dq_oe` returns to 0.
- R8: The column address is captured when the first column strobe falls after both were high. A second strobe falling later in that column cycle uses the captured column, not the current `addr`. The array row is `addr[ROW_BITS-1:0]` at the row strobe fall, and the column is `addr[COL_BITS-1:0]`.
- R9: `proto_err` pulses for one clock when the write strobe falls while the row strobe is low and both column strobes are high.
- R10: The refresh counter wraps from 1023 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 2*LANE_W | Write data, lane 1 in the upper half |
| dq_out | output | 2*LANE_W | Read data |
| dq_oe | output | 2 | Per-lane output drive enable |
| cyc_type | output | 3 | Decoded cycle kind |
| rf_pulse | output | 1 | One-clock pulse at each row strobe fall |
| rf_row | output | RCNT_W | Row refreshed by that fall |
| proto_err | output | 1 | Write strobe fell with no column strobe active |

## Verification
The wrap of the refresh counter is the hardest state to reach, because the counter can only be seen by running counter refreshes. The bench tracks the expected counter value across every earlier test. It then issues short refresh cycles, with a column strobe first and then the row strobe, until the counter sits at 1023, and checks that the next refresh reports 0. The early-write hold is also reached only by a given order of strobes. The write strobe goes low before the column strobe, then rises while the column strobe stays low and the output enable goes low.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;
   typedef enum logic [1:0] {
      MODE_IDLE = 2'd0,
      MODE_ACC  = 2'd1,
      MODE_CBR  = 2'd2
   } dram_mode_e;

   typedef enum logic [2:0] {
      CYC_STBY  = 3'd0,
      CYC_CBR   = 3'd1,
      CYC_ROWON = 3'd2,
      CYC_READ  = 3'd3,
      CYC_WRITE = 3'd4,
      CYC_HOLD  = 3'd5
   } dram_cyc_e;
endpackage

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [CNT_W-1:0] cnt
);
   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("CNT_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (adv) cnt <= cnt + 1'b1;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> cnt == $past(cnt) + 1'b1); // R10

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(cnt)); // R3
endmodule

// File: rtl/dram_lane_store.sv
module dram_lane_store #(
   parameter int AW = 6,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   generate
      if (DEPTH > 4096) begin : g_too_deep
         $error("lane store depth too large");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wr_data;
      rd_data <= mem[addr];
   end
endmodule

// File: rtl/dram_strobe_decode.sv
module dram_strobe_decode
   import dram_strobe_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int ROW_BITS = 3,
   parameter int COL_BITS = 3,
   parameter int RCNT_W   = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ras_n,
   input  logic [1:0]          cas_n,
   input  logic                we_n,
   input  logic                oe_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [RCNT_W-1:0]   cnt,
   output logic [ROW_BITS-1:0] row_q,
   output logic [COL_BITS-1:0] col_nx,
   output logic [1:0]          wr_lane,
   output logic [1:0]          oe_q,
   output logic [2:0]          cyc_q,
   output logic                rf_pulse,
   output logic [RCNT_W-1:0]   rf_row,
   output logic                adv,
   output logic                proto_q
);
   dram_mode_e          mode_q, mode_nx;
   logic                ras_s, we_s, early_q, early_nx;
   logic [1:0]          cas_s, oe_nx;
   logic [COL_BITS-1:0] col_q;
   logic                cas_any, ras_fall, acc, cas_first;
   dram_cyc_e           cyc_nx;

   assign cas_any  = ~&cas_n;
   assign ras_fall = ras_s & ~ras_n;

   always_comb begin
      if (ras_n)         mode_nx = MODE_IDLE;
      else if (ras_fall) mode_nx = cas_any ? MODE_CBR : MODE_ACC;
      else               mode_nx = mode_q;
   end

   assign acc       = (mode_nx == MODE_ACC);
   assign cas_first = acc & cas_any & (&cas_s);
   assign col_nx    = cas_first ? addr[COL_BITS-1:0] : col_q;
   assign early_nx  = cas_first ? ~we_n : (acc & cas_any & early_q);
   assign adv       = ras_fall & cas_any;

   generate
      for (genvar l = 0; l < 2; l++) begin : g_lane
         assign wr_lane[l] = acc & ~cas_n[l] & ~we_n;
         assign oe_nx[l]   = acc & ~cas_n[l] & we_n & ~oe_n & ~early_nx;
      end
   endgenerate

   always_comb begin
      if (mode_nx == MODE_IDLE)     cyc_nx = CYC_STBY;
      else if (mode_nx == MODE_CBR) cyc_nx = CYC_CBR;
      else if (!cas_any)            cyc_nx = CYC_ROWON;
      else if (!we_n)               cyc_nx = CYC_WRITE;
      else if (!oe_n && !early_nx)  cyc_nx = CYC_READ;
      else                          cyc_nx = CYC_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_IDLE;
         ras_s    <= 1'b1;
         cas_s    <= 2'b11;
         we_s     <= 1'b1;
         early_q  <= 1'b0;
         col_q    <= '0;
         row_q    <= '0;
         oe_q     <= 2'b00;
         cyc_q    <= CYC_STBY;
         rf_pulse <= 1'b0;
         rf_row   <= '0;
         proto_q  <= 1'b0;
      end else begin
         mode_q   <= mode_nx;
         ras_s    <= ras_n;
         cas_s    <= cas_n;
         we_s     <= we_n;
         early_q  <= early_nx;
         col_q    <= col_nx;
         if (ras_fall && !cas_any) row_q <= addr[ROW_BITS-1:0];
         oe_q     <= oe_nx;
         cyc_q    <= cyc_nx;
         rf_pulse <= ras_fall;
         if (ras_fall) rf_row <= cas_any ? cnt : addr[RCNT_W-1:0];
         proto_q  <= ~ras_n & (&cas_n) & we_s & ~we_n;
      end
   end

   AST_STBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      ras_n |=> (oe_q == 2'b00)); // R1

   AST_LO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      cas_n[0] |=> !oe_q[0]); // R4

   AST_HI_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      cas_n[1] |=> !oe_q[1]); // R4

   AST_WR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |=> (oe_q == 2'b00)); // R5

   AST_EARLY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      early_q |-> (oe_q == 2'b00)); // R6

   AST_NO_ERR_STBY: assert property (@(posedge clk) disable iff (!rst_n)
      ras_n |=> !proto_q); // R9
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl #(
   parameter int ADDR_W   = 10,
   parameter int ROW_BITS = 3,
   parameter int COL_BITS = 3,
   parameter int LANE_W   = 8,
   parameter int RCNT_W   = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ras_n,
   input  logic                  lcas_n,
   input  logic                  ucas_n,
   input  logic                  we_n,
   input  logic                  oe_n,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [2*LANE_W-1:0]   dq_in,
   output logic [2*LANE_W-1:0]   dq_out,
   output logic [1:0]            dq_oe,
   output logic [2:0]            cyc_type,
   output logic                  rf_pulse,
   output logic [RCNT_W-1:0]     rf_row,
   output logic                  proto_err
);
   localparam int CELL_AW = ROW_BITS + COL_BITS;

   generate
      if (ROW_BITS > ADDR_W || COL_BITS > ADDR_W || RCNT_W > ADDR_W) begin : g_bad_addr
         $error("array or counter wider than the address pins");
      end
   endgenerate

   logic [ROW_BITS-1:0] row_q;
   logic [COL_BITS-1:0] col_nx;
   logic [1:0]          wr_lane;
   logic [RCNT_W-1:0]   cnt;
   logic                adv;

   dram_strobe_decode #(
      .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .RCNT_W(RCNT_W)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n({ucas_n, lcas_n}),
      .we_n(we_n), .oe_n(oe_n), .addr(addr), .cnt(cnt),
      .row_q(row_q), .col_nx(col_nx), .wr_lane(wr_lane), .oe_q(dq_oe),
      .cyc_q(cyc_type), .rf_pulse(rf_pulse), .rf_row(rf_row), .adv(adv),
      .proto_q(proto_err)
   );

   dram_refresh_ctr #(.CNT_W(RCNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .adv(adv), .cnt(cnt)
   );

   generate
      for (genvar l = 0; l < 2; l++) begin : g_store
         dram_lane_store #(.AW(CELL_AW), .DW(LANE_W)) u_lane (
            .clk(clk), .wr_en(wr_lane[l]), .addr({row_q, col_nx}),
            .wr_data(dq_in[l*LANE_W +: LANE_W]),
            .rd_data(dq_out[l*LANE_W +: LANE_W])
         );
      end
   endgenerate
endmodule

// File: tb/tb_dram_strobe_ctrl.sv
`timescale 1ns/100ps
module tb_dram_strobe_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [9:0]  addr = '0;
   logic [15:0] dq_in = '0;
   logic [15:0] dq_out;
   logic [1:0]  dq_oe;
   logic [2:0]  cyc_type;
   logic        rf_pulse, proto_err;
   logic [9:0]  rf_row;

   int n_chk = 0, n_bad = 0;
   int exp_cnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dram_strobe_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
      .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
      .dq_oe(dq_oe), .cyc_type(cyc_type), .rf_pulse(rf_pulse), .rf_row(rf_row),
      .proto_err(proto_err)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   // drive pins, let one rising edge sample them, return at the next falling edge
   task automatic pins(input logic r, input logic lc, input logic uc, input logic w,
                       input logic o, input logic [9:0] a, input logic [15:0] d);
      ras_n = r; lcas_n = lc; ucas_n = uc; we_n = w; oe_n = o; addr = a; dq_in = d;
      @(negedge clk);
   endtask

   task automatic idle();
      pins(1, 1, 1, 1, 1, 10'h0, 16'h0);
   endtask

   task automatic cbr_once(input string tag);
      pins(1, 0, 1, 1, 1, 10'h0, 16'h0);
      pins(0, 0, 1, 1, 1, 10'h0, 16'h0);
      chk({tag, " R2 cyc"}, cyc_type, 1);
      chk({tag, " R2 pulse"}, rf_pulse, 1);
      chk({tag, " R2/R10 row"}, rf_row, exp_cnt);
      exp_cnt = (exp_cnt + 1) % 1024;
      idle();
   endtask

   task automatic t_reset();
      chk("R1 reset cyc", cyc_type, 0);
      chk("R1 reset oe", dq_oe, 0);
      chk("R9 reset err", proto_err, 0);
      chk("R2 reset pulse", rf_pulse, 0);
   endtask

   task automatic t_cbr();
      cbr_once("cbr0");
      cbr_once("cbr1");
   endtask

   task automatic t_ras_only();
      pins(0, 1, 1, 1, 0, 10'h155, 16'h0);
      chk("R3 pulse", rf_pulse, 1);
      chk("R3 row", rf_row, 10'h155);
      chk("R3 cyc", cyc_type, 2);
      chk("R3 oe", dq_oe, 0);
      idle();
      cbr_once("R3 counter untouched");
   endtask

   // early word write row 5 col 2, then WE rises with OE low
   task automatic t_early_write();
      pins(0, 1, 1, 1, 1, 10'd5, 16'h0);
      pins(0, 0, 0, 0, 1, 10'd2, 16'hA55A);
      chk("R5 early cyc", cyc_type, 4);
      chk("R5 early oe", dq_oe, 0);
      pins(0, 0, 0, 1, 0, 10'd2, 16'h0);
      chk("R6 early hold oe", dq_oe, 0);
      chk("R6 early hold cyc", cyc_type, 5);
      idle();
      chk("R1 standby oe", dq_oe, 0);
      chk("R1 standby cyc", cyc_type, 0);
   endtask

   task automatic rd(input string tag, input logic [9:0] row, input logic [9:0] col,
                     input logic lc, input logic uc, input int exp_oe, input int exp_d);
      pins(0, 1, 1, 1, 1, row, 16'h0);
      pins(0, lc, uc, 1, 0, col, 16'h0);
      chk({tag, " R4 oe"}, dq_oe, exp_oe);
      chk({tag, " R4 cyc"}, cyc_type, 3);
      if (exp_oe[0]) chk({tag, " R4 lo data"}, dq_out[7:0], exp_d & 8'hFF);
      if (exp_oe[1]) chk({tag, " R4 hi data"}, dq_out[15:8], (exp_d >> 8) & 8'hFF);
      idle();
   endtask

   task automatic t_reads();
      rd("word", 10'd5, 10'd2, 0, 0, 3, 16'hA55A);
      rd("lo byte", 10'd5, 10'd2, 0, 1, 1, 16'h005A);
      rd("hi byte", 10'd5, 10'd2, 1, 0, 2, 16'hA500);
   endtask

   task automatic t_byte_write();
      pins(0, 1, 1, 1, 1, 10'd5, 16'h0);
      pins(0, 1, 0, 0, 1, 10'd2, 16'h3CC3);
      chk("R5 byte wr oe", dq_oe, 0);
      idle();
      rd("R5 after hi write", 10'd5, 10'd2, 0, 0, 3, 16'h3C5A);
   endtask

   task automatic t_oe_write();
      pins(0, 1, 1, 1, 1, 10'd1, 16'h0);
      pins(0, 0, 0, 1, 0, 10'd7, 16'h0);
      chk("R7 read phase oe", dq_oe, 3);
      pins(0, 0, 0, 0, 1, 10'd7, 16'h1234);
      chk("R7 write phase oe", dq_oe, 0);
      chk("R7 write phase cyc", cyc_type, 4);
      idle();
      rd("R7 readback", 10'd1, 10'd7, 0, 0, 3, 16'h1234);
   endtask

   task automatic t_col_latch();
      pins(0, 1, 1, 1, 1, 10'd6, 16'h0);
      pins(0, 0, 0, 0, 1, 10'd6, 16'h0000);
      idle();
      pins(0, 1, 1, 1, 1, 10'd6, 16'h0);
      pins(0, 0, 1, 0, 1, 10'd4, 16'hBEEF);
      pins(0, 0, 0, 0, 1, 10'd6, 16'hBEEF);
      idle();
      rd("R8 latched col", 10'd6, 10'd4, 0, 0, 3, 16'hBEEF);
      rd("R8 other col", 10'd6, 10'd6, 0, 0, 3, 16'h0000);
   endtask

   task automatic t_proto();
      pins(0, 1, 1, 1, 1, 10'd3, 16'h0);
      chk("R9 no err", proto_err, 0);
      pins(0, 1, 1, 0, 1, 10'd3, 16'h0);
      chk("R9 err", proto_err, 1);
      pins(0, 1, 1, 0, 1, 10'd3, 16'h0);
      chk("R9 one pulse", proto_err, 0);
      idle();
   endtask

   task automatic t_wrap();
      while (exp_cnt != 1023) begin
         pins(1, 0, 1, 1, 1, 10'h0, 16'h0);
         pins(0, 0, 1, 1, 1, 10'h0, 16'h0);
         exp_cnt++;
         idle();
      end
      cbr_once("R10 at 1023");
      cbr_once("R10 wrapped");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_cbr();
      t_ras_only();
      t_early_write();
      t_reads();
      t_byte_write();
      t_oe_write();
      t_col_latch();
      t_proto();
      t_wrap();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end
endmodule